// File: doc/BRIEF.md
# Flagged Multi-Mode Barrel Shifter

This block moves an N-bit word left or right by any distance from 0 to N-1 in a single combinational step. A two-bit run-time code picks one of three shift types: logical (zero fill), arithmetic (sign fill on right shifts), or rotate (bits wrap from one end to the other). The block holds no state, so its outputs depend only on the current inputs.

For logical and arithmetic shifts, two flags report lost precision. Overflow means significant bits left the top of the word. In arithmetic mode it also means a bit that differs from the sign moved into or past the sign position. Underflow means a right shift reduced the word to its fill pattern alone, and at least one significant bit was lost at the bottom. The shifter is built as one multiplexer stage per distance bit. The flags come from masks of the bits shifted out, not from the shifted word.

Top module: `flagged_barrel_shifter`

## Requirements
- R1: The outputs are a combinational function of the current inputs only. With distance 0, result equals the data input and both flags are 0, for any direction and shift type.
- R2: Direction 0 shifts toward the most significant bit (left) and direction 1 shifts toward bit 0 (right). Shift-type code 2'b00 selects logical, 2'b01 arithmetic and 2'b10 rotate.
- R3: In logical mode, vacated positions fill with 0 in both directions.
- R4: A logical left shift by s raises overflow exactly when a 1 sits in any of the top s input bits. A left shift of any type never raises underflow.
- R5: A logical right shift raises underflow exactly when the result is all zeros and at least one 1 was shifted out of the bottom. A right shift of any type never raises overflow.
- R6: An arithmetic left shift by s fills zeros at the bottom. It raises overflow exactly when an input bit at positions N-1-s through N-2 differs from input bit N-1.
- R7: An arithmetic right shift fills the vacated top positions with copies of input bit N-1.
- R8: An arithmetic right shift raises underflow exactly when every result bit equals the sign and at least one bit shifted out differs from the sign.
- R9: In rotate mode, bits leaving one end re-enter at the other end, and both flags are 0.
- R10: Shift-type code 2'b11 behaves exactly like logical mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Word to shift |
| dist_i | input | clog2(N) | Shift distance in bit positions |
| dir_i | input | 1 | 0 = left, 1 = right |
| kind_i | input | 2 | Shift type: 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| result_o | output | N | Shifted word |
| overflow_o | output | 1 | Significant bits lost at the top or across the sign |
| underflow_o | output | 1 | Right shift collapsed the word to its fill pattern |

## Verification
The bench builds two instances, one at the default width of 8 and one at width 4. With these widths, every combination of data, distance, direction and shift-type code can be applied exhaustively. This includes the unused code 2'b11, the full-distance shifts that leave one bit, and the most negative and most positive values, where the sign-crossing rules are tightest. At width 4, the hand-worked vectors for the flag equations can be written out bit by bit, and the same behaviour is then confirmed at width 8 against an iterative reference.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  typedef enum logic [1:0] {
    SHK_LOGIC     = 2'b00,
    SHK_ARITH     = 2'b01,
    SHK_ROTATE    = 2'b10,
    SHK_LOGIC_ALT = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int N   = 8,
  parameter int AMT = 1
) (
  input  logic [N-1:0] d_i,
  input  logic         en_i,
  input  logic         dir_i,
  input  logic         rot_i,
  input  logic         fill_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] left_w;
  logic [N-1:0] right_w;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i >= AMT) begin : g_l_in
      assign left_w[i] = d_i[i-AMT];
    end else begin : g_l_wrap
      assign left_w[i] = rot_i & d_i[i+N-AMT];
    end
    if (i + AMT < N) begin : g_r_in
      assign right_w[i] = d_i[i+AMT];
    end else begin : g_r_wrap
      assign right_w[i] = rot_i ? d_i[i+AMT-N] : fill_i;
    end
  end

  assign q_o = !en_i ? d_i : (dir_i ? right_w : left_w);
endmodule

// File: rtl/bshift_flags.sv
module bshift_flags #(
  parameter int N  = 8,
  parameter int DW = $clog2(N)
) (
  input  logic [N-1:0]  data_i,
  input  logic [DW-1:0] dist_i,
  input  logic          dir_i,
  input  logic          arith_i,
  input  logic          rot_i,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [N-1:0] ONES = '1;

  logic [N-1:0] xr;
  logic [N-1:0] top_mask;
  logic [N-1:0] low_mask;
  logic [DW:0]  dist_w;
  logic [DW:0]  dist_p1;
  logic         left_ovf;
  logic         right_unf;

  always_comb begin
    dist_w  = {1'b0, dist_i};
    dist_p1 = dist_w + 1'b1;
    // significance is measured relative to the fill value
    xr       = arith_i ? (data_i ^ {N{data_i[N-1]}}) : data_i;
    // arithmetic left also watches bits landing on the sign position
    top_mask = ~(ONES >> (arith_i ? dist_p1 : dist_w));
    low_mask = ~(ONES << dist_i);
    left_ovf  = |(xr & top_mask);
    right_unf = ((xr >> dist_i) == '0) && (|(xr & low_mask));
    ovf_o = !rot_i && !dir_i && left_ovf;
    unf_o = !rot_i &&  dir_i && right_unf;
  end
endmodule

// File: rtl/flagged_barrel_shifter.sv
module flagged_barrel_shifter
  import barrel_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = $clog2(N)
) (
  input  logic [N-1:0]  data_i,
  input  logic [DW-1:0] dist_i,
  input  logic          dir_i,
  input  logic [1:0]    kind_i,
  output logic [N-1:0]  result_o,
  output logic          overflow_o,
  output logic          underflow_o
);
  shift_kind_e kind;
  logic        arith;
  logic        rot;
  logic        fill;
  logic [N-1:0] stage_w [DW+1];

  assign kind  = shift_kind_e'(kind_i);
  assign arith = (kind == SHK_ARITH);
  assign rot   = (kind == SHK_ROTATE);
  assign fill  = arith & data_i[N-1];

  assign stage_w[0] = data_i;
  for (genvar k = 0; k < DW; k++) begin : g_stage
    bshift_stage #(
      .N  (N),
      .AMT(1 << k)
    ) u_stage (
      .d_i   (stage_w[k]),
      .en_i  (dist_i[k]),
      .dir_i (dir_i),
      .rot_i (rot),
      .fill_i(fill),
      .q_o   (stage_w[k+1])
    );
  end
  assign result_o = stage_w[DW];

  bshift_flags #(
    .N (N),
    .DW(DW)
  ) u_flags (
    .data_i (data_i),
    .dist_i (dist_i),
    .dir_i  (dir_i),
    .arith_i(arith),
    .rot_i  (rot),
    .ovf_o  (overflow_o),
    .unf_o  (underflow_o)
  );

  always_comb begin
    if (!$isunknown({data_i, dist_i, dir_i, kind_i})) begin
      if (dist_i == '0)
        AST_ZERO_DIST_PASS: assert (result_o == data_i && !overflow_o && !underflow_o); // R1
      if (!dir_i)
        AST_LEFT_NO_UNDERFLOW: assert (!underflow_o); // R4
      if (dir_i)
        AST_RIGHT_NO_OVERFLOW: assert (!overflow_o); // R5
      if (rot)
        AST_ROTATE_NO_FLAGS: assert (!overflow_o && !underflow_o); // R9
      if (rot)
        AST_ROTATE_KEEPS_ONES: assert ($countones(result_o) == $countones(data_i)); // R9
      if (underflow_o)
        AST_UNDERFLOW_FILL_ONLY: assert (result_o == {N{fill}}); // R8
    end
  end
endmodule

// File: tb/flagged_barrel_shifter_test.sv
module flagged_barrel_shifter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] d8;
  logic [2:0] s8;
  logic       dir8;
  logic [1:0] k8;
  logic [7:0] r8;
  logic       ov8, un8;

  logic [3:0] d4;
  logic [1:0] s4;
  logic       dir4;
  logic [1:0] k4;
  logic [3:0] r4;
  logic       ov4, un4;

  flagged_barrel_shifter #(.N(8)) uut (
    .data_i(d8), .dist_i(s8), .dir_i(dir8), .kind_i(k8),
    .result_o(r8), .overflow_o(ov8), .underflow_o(un8)
  );

  flagged_barrel_shifter #(.N(4)) uut_n4 (
    .data_i(d4), .dist_i(s4), .dir_i(dir4), .kind_i(k4),
    .result_o(r4), .overflow_o(ov4), .underflow_o(un4)
  );

  // {kind, dir, dist, data, result, ovf, unf}, width 4
  localparam logic [14:0] VEC [13] = '{
    {2'b00, 1'b0, 2'd1, 4'b1001, 4'b0010, 1'b1, 1'b0}, // R4
    {2'b00, 1'b0, 2'd3, 4'b0001, 4'b1000, 1'b0, 1'b0}, // R4
    {2'b00, 1'b1, 2'd1, 4'b0001, 4'b0000, 1'b0, 1'b1}, // R5
    {2'b00, 1'b1, 2'd2, 4'b0110, 4'b0001, 1'b0, 1'b0}, // R5
    {2'b01, 1'b0, 2'd2, 4'b0010, 4'b1000, 1'b1, 1'b0}, // R6
    {2'b01, 1'b0, 2'd1, 4'b1100, 4'b1000, 1'b0, 1'b0}, // R6
    {2'b01, 1'b1, 2'd1, 4'b1010, 4'b1101, 1'b0, 1'b0}, // R7
    {2'b01, 1'b1, 2'd2, 4'b1101, 4'b1111, 1'b0, 1'b1}, // R8
    {2'b01, 1'b1, 2'd3, 4'b0011, 4'b0000, 1'b0, 1'b1}, // R8
    {2'b10, 1'b0, 2'd1, 4'b1000, 4'b0001, 1'b0, 1'b0}, // R9
    {2'b10, 1'b1, 2'd1, 4'b0001, 4'b1000, 1'b0, 1'b0}, // R9
    {2'b11, 1'b0, 2'd1, 4'b1001, 4'b0010, 1'b1, 1'b0}, // R10
    {2'b00, 1'b1, 2'd0, 4'b1011, 4'b1011, 1'b0, 1'b0}  // R1
  };

  // iterative reference, one position per step
  function automatic void ref_shift(input int w, input logic [7:0] d, input int s,
                                    input bit dir, input logic [1:0] k,
                                    output logic [7:0] res, output logic ov, output logic un);
    logic [7:0] m;
    logic       sg, lost;
    bit ar, rt;
    ar = (k == 2'b01);
    rt = (k == 2'b10);
    m  = (w == 8) ? 8'hFF : 8'h0F;
    res = d & m;
    sg = res[w-1];
    ov = 1'b0;
    lost = 1'b0;
    for (int i = 0; i < s; i++) begin
      if (!dir) begin
        logic top;
        top = res[w-1];
        res = ((res << 1) | (rt ? {7'b0, top} : 8'b0)) & m;
        if (!ar && top) ov = 1'b1;
        if (ar && res[w-1] != sg) ov = 1'b1;
      end else begin
        logic bot;
        bot = res[0];
        res = res >> 1;
        res[w-1] = rt ? bot : (ar ? sg : 1'b0);
        if (bot != (ar ? sg : 1'b0)) lost = 1'b1;
      end
    end
    un = dir && !rt && lost && (res == ((ar && sg) ? m : 8'h00));
    if (rt || dir) ov = 1'b0;
  endfunction

  function automatic string req_of(input logic [1:0] k, input bit dir, input int s);
    if (s == 0) return "R1";
    if (k == 2'b10) return "R9";
    if (k == 2'b11) return "R10";
    if (k == 2'b01) return dir ? "R8" : "R6";
    return dir ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] er;
    logic eo, eu;
    d8 = '0; s8 = '0; dir8 = 1'b0; k8 = '0;
    d4 = '0; s4 = '0; dir4 = 1'b0; k4 = '0;
    @(negedge clk);
    #1;
    // R1 idle state: zero input, zero distance
    check("R1", {1'b0, r8, ov8 | un8}, 9'd0);

    // hand-worked width-4 vectors
    foreach (VEC[i]) begin
      @(negedge clk);
      {k4, dir4, s4, d4} = VEC[i][14:6];
      #1;
      check(req_of(k4, dir4, int'(s4)) == "R1" ? "R1" : req_of(k4, dir4, int'(s4)),
            {3'b0, r4, ov4, un4}, {3'b0, VEC[i][5:0]});
    end

    // exhaustive width 4
    for (int k = 0; k < 4; k++)
      for (int dr = 0; dr < 2; dr++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 16; d++) begin
            @(negedge clk);
            k4 = 2'(k); dir4 = dr[0]; s4 = 2'(s); d4 = 4'(d);
            #1;
            ref_shift(4, 8'(d), s, dr[0], 2'(k), er, eo, eu);
            check(req_of(2'(k), dr[0], s), {3'b0, r4, ov4, un4}, {3'b0, er[3:0], eo, eu});
          end

    // exhaustive width 8
    for (int k = 0; k < 4; k++)
      for (int dr = 0; dr < 2; dr++)
        for (int s = 0; s < 8; s++)
          for (int d = 0; d < 256; d++) begin
            @(negedge clk);
            k8 = 2'(k); dir8 = dr[0]; s8 = 3'(s); d8 = 8'(d);
            #1;
            ref_shift(8, 8'(d), s, dr[0], 2'(k), er, eo, eu);
            check(req_of(2'(k), dr[0], s), {r8, ov8 ^ un8}, {er, eo ^ eu});
            if (ov8 !== eo || un8 !== eu)
              check(req_of(2'(k), dr[0], s), {7'b0, ov8, un8}, {7'b0, eo, eu});
          end

    // directed width-8 corners
    @(negedge clk);
    k8 = 2'b01; dir8 = 1'b0; s8 = 3'd7; d8 = 8'h80; #1;
    check("R6", {r8, ov8}, {8'h00, 1'b1});
    @(negedge clk);
    k8 = 2'b01; dir8 = 1'b1; s8 = 3'd7; d8 = 8'h80; #1;
    check("R7", {r8, un8}, {8'hFF, 1'b1});
    @(negedge clk);
    k8 = 2'b01; dir8 = 1'b1; s8 = 3'd7; d8 = 8'hFF; #1;
    check("R8", {r8, un8}, {8'hFF, 1'b0});
    @(negedge clk);
    k8 = 2'b00; dir8 = 1'b1; s8 = 3'd4; d8 = 8'hF0; #1;
    check("R3", {r8, un8}, {8'h0F, 1'b0});
    @(negedge clk);
    k8 = 2'b00; dir8 = 1'b0; s8 = 3'd4; d8 = 8'h0F; #1;
    check("R3", {r8, ov8}, {8'hF0, 1'b0});
    @(negedge clk);
    k8 = 2'b10; dir8 = 1'b0; s8 = 3'd3; d8 = 8'hA5; #1;
    check("R9", {r8, ov8 | un8}, {8'h2D, 1'b0});
    @(negedge clk);
    k8 = 2'b00; dir8 = 1'b0; s8 = 3'd1; d8 = 8'h01; #1;
    check("R2", {r8, ov8}, {8'h02, 1'b0});

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule